// File: doc/BRIEF.md
# Occupancy-Driven Fetch Thread Arbiter

This block decides, once per cycle, which hardware thread of a simultaneously multithreaded out-of-order core supplies the program counter for instruction fetch. For every thread it keeps a live count of the instructions that thread holds in the shared instruction window. Dispatch events increase the count, retire events decrease it, and a flush resets it.

The arbiter favours the thread holding the fewest window entries. This stops one thread that stalls often from filling the window. A thread that software marks as spinning on a lock drops below every thread that is not spinning. When several threads are active, each is capped at an equal share of the window. A lone active thread may use the whole window. Stalled and inactive threads are never chosen. Ties on occupancy rotate fairly among the threads.

The choice is combinational from the current flags and the registered counts. Dispatch, retire and flush inputs take effect on the counts from the next cycle.

Top module: `fetch_thread_sel`

## Requirements
- R1: After reset every occupancy count is zero and the rotation pointer is at thread 0, so a first request from all threads selects thread 0.
- R2: Each cycle, a thread's occupancy count changes by its dispatch count minus its retire count; the new value is used for selection from the next cycle.
- R3: Among the threads in the candidate pool, the one with the smallest occupancy count is selected.
- R4: Among candidates with equal lowest occupancy, the first one found scanning upward (with wraparound) from the rotation pointer wins. After every valid selection, the pointer moves to the thread after the selected one.
- R5: A thread whose spin flag is set is selected only when no eligible thread without the spin flag exists. In that case, eligible spinning threads form the pool.
- R6: A thread whose stall flag is set is never selected.
- R7: With N > 1 active threads, a thread whose occupancy is at least WIN/N (integer division) is ineligible.
- R8: With exactly one active thread, that thread stays eligible until its occupancy reaches WIN.
- R9: A flush for a thread sets its occupancy to zero on the next cycle and overrides any dispatch for that thread in the same cycle.
- R10: When no thread is eligible, fetch_vld is 0, fetch_tid is 0 and the rotation pointer holds.
- R11: A thread whose active flag is clear is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| thr_active | input | NTHR | Per-thread active flag |
| thr_stall | input | NTHR | Per-thread stall flag |
| thr_spin | input | NTHR | Per-thread spin-on-lock hint |
| disp_cnt | input | NTHR*CW | Per-thread instructions dispatched this cycle, thread 0 in the low bits |
| ret_cnt | input | NTHR*CW | Per-thread instructions retired this cycle, thread 0 in the low bits |
| thr_flush | input | NTHR | Per-thread flush, clears the count |
| fetch_tid | output | $clog2(NTHR) | Selected thread |
| fetch_vld | output | 1 | A thread was selected this cycle |

## Verification
The assertions assume that the dispatch and retire counts keep every occupancy count between zero and WIN. They also assume no thread retires more than it holds, and no thread dispatches past its window share. Under those conditions the counts never wrap, and the comparisons against the cap and between threads remain meaningful.

The stimulus keeps a running tally of each thread's occupancy. Retire counts never exceed the tally, and the only dispatch that would cross a thread's cap is discarded by a flush in the same cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Integer share of a window of win entries among n users (n >= 1).
  function automatic int win_share(input int win, input int n);
    return (n < 1) ? win : win / n;
  endfunction
endpackage

// File: rtl/fts_occ_ctr.sv
module fts_occ_ctr #(
  parameter int OW = 5,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] disp,
  input  logic [CW-1:0] ret,
  output logic [OW-1:0] occ
);
  logic [OW-1:0] occ_n;
  logic          occ_en;

  always_comb begin
    occ_en = flush || (disp != ret);
    if (flush) occ_n = '0;
    else       occ_n = occ + OW'(disp) - OW'(ret);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_n;
  end
endmodule

// File: rtl/fts_cap.sv
module fts_cap #(
  parameter int NTHR = 4,
  parameter int WIN  = 16,
  parameter int OW   = 5
) (
  input  logic [NTHR-1:0] active,
  output logic [OW-1:0]   cap
);
  import fts_pkg::*;
  int nact;

  always_comb begin
    nact = $countones(active);
    cap  = OW'(WIN);
    for (int k = 2; k <= NTHR; k++) begin
      if (nact == k) cap = OW'(win_share(WIN, k));
    end
  end
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int NTHR = 4,
  parameter int OW   = 5,
  parameter int TW   = 2
) (
  input  logic [NTHR-1:0]         elig,
  input  logic [NTHR-1:0]         spin,
  input  logic [NTHR-1:0][OW-1:0] occ,
  input  logic [TW-1:0]           ptr,
  output logic [TW-1:0]           sel,
  output logic                    vld
);
  logic [NTHR-1:0] calm;
  logic [NTHR-1:0] pool;
  logic [OW-1:0]   best;
  logic [TW-1:0]   idx;

  always_comb begin
    calm = elig & ~spin;
    pool = (calm != '0) ? calm : elig;
    vld  = 1'b0;
    best = '0;
    sel  = '0;
    idx  = '0;
    for (int i = 0; i < NTHR; i++) begin
      idx = TW'((int'(ptr) + i) % NTHR);
      if (pool[idx] && (!vld || occ[idx] < best)) begin
        vld  = 1'b1;
        best = occ[idx];
        sel  = idx;
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR = 4,
  parameter int WIN  = 16,
  parameter int CW   = 3,
  localparam int OW  = $clog2(WIN + 1),
  localparam int TW  = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  thr_active,
  input  logic [NTHR-1:0]  thr_stall,
  input  logic [NTHR-1:0]  thr_spin,
  input  logic [NTHR*CW-1:0] disp_cnt,
  input  logic [NTHR*CW-1:0] ret_cnt,
  input  logic [NTHR-1:0]  thr_flush,
  output logic [TW-1:0]    fetch_tid,
  output logic             fetch_vld
);
  logic [1:0]             rst_sync;
  logic                   rst_q;
  logic [NTHR-1:0][OW-1:0] occ;
  logic [OW-1:0]          cap;
  logic [NTHR-1:0]        elig;
  logic [TW-1:0]          ptr;
  logic [TW-1:0]          ptr_n;
  logic                   ptr_en;

  // Reset: assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    fts_occ_ctr #(.OW(OW), .CW(CW)) u_ctr (
      .clk  (clk),
      .rst_n(rst_q),
      .flush(thr_flush[t]),
      .disp (disp_cnt[t*CW +: CW]),
      .ret  (ret_cnt[t*CW +: CW]),
      .occ  (occ[t])
    );
    assign elig[t] = thr_active[t] && !thr_stall[t] && (occ[t] < cap);
  end

  fts_cap #(.NTHR(NTHR), .WIN(WIN), .OW(OW)) u_cap (
    .active(thr_active),
    .cap   (cap)
  );

  fts_pick #(.NTHR(NTHR), .OW(OW), .TW(TW)) u_pick (
    .elig(elig),
    .spin(thr_spin),
    .occ (occ),
    .ptr (ptr),
    .sel (fetch_tid),
    .vld (fetch_vld)
  );

  always_comb begin
    ptr_en = fetch_vld;
    if (int'(fetch_tid) == NTHR - 1) ptr_n = '0;
    else                             ptr_n = fetch_tid + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_n;
  end
endmodule

// File: rtl/fts_chk.sv
module fts_chk #(
  parameter int NTHR = 4,
  parameter int OW   = 5,
  parameter int TW   = 2
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic [NTHR-1:0]         active,
  input logic [NTHR-1:0]         stall,
  input logic [NTHR-1:0]         spin,
  input logic [NTHR-1:0]         flush,
  input logic [TW-1:0]           sel,
  input logic                    vld,
  input logic [NTHR-1:0][OW-1:0] occ,
  input logic [OW-1:0]           cap,
  input logic [NTHR-1:0]         elig
);
  logic beaten;

  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < NTHR; j++) begin
      if (elig[j] && !spin[j] && occ[j] < occ[sel]) beaten = 1'b1;
    end
  end

  // R6
  stall_pick_chk: assert property (@(posedge clk) disable iff (!rst_q)
    vld |-> !stall[sel]);

  // R11
  idle_thread_chk: assert property (@(posedge clk) disable iff (!rst_q)
    vld |-> active[sel]);

  // R7
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    vld |-> (occ[sel] < cap));

  // R5
  spin_demote_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (vld && spin[sel]) |-> ((elig & ~spin) == '0));

  // R3
  fewest_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (vld && !spin[sel]) |-> !beaten);

  // R10
  none_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (elig == '0) |-> (!vld && sel == '0));

  for (genvar t = 0; t < NTHR; t++) begin : g_fl
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
      flush[t] |=> (occ[t] == '0));
  end
endmodule

bind fetch_thread_sel fts_chk #(.NTHR(NTHR), .OW(OW), .TW(TW)) u_chk (
  .clk   (clk),
  .rst_q (rst_q),
  .active(thr_active),
  .stall (thr_stall),
  .spin  (thr_spin),
  .flush (thr_flush),
  .sel   (fetch_tid),
  .vld   (fetch_vld),
  .occ   (occ),
  .cap   (cap),
  .elig  (elig)
);

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
  localparam int NTHR = 4;
  localparam int WIN  = 16;
  localparam int CW   = 3;

  typedef struct {
    logic       v;
    logic [1:0] s;
    string      r;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NTHR-1:0]   act, stl, spn, fl;
  logic [NTHR*CW-1:0] dsp, rtr;
  logic [1:0]        tid;
  logic              vld;
  int                n_run = 0;
  int                n_bad = 0;
  bit                done = 0;
  exp_t              q[$];

  always #2 clk = ~clk;

  fetch_thread_sel #(.NTHR(NTHR), .WIN(WIN), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_active(act), .thr_stall(stl),
    .thr_spin(spn), .disp_cnt(dsp), .ret_cnt(rtr), .thr_flush(fl),
    .fetch_tid(tid), .fetch_vld(vld)
  );

  function automatic logic [11:0] pk(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic step(input logic [3:0] a, input logic [3:0] s, input logic [3:0] p,
                      input logic [11:0] d, input logic [11:0] r, input logic [3:0] f,
                      input logic ev, input logic [1:0] es, input string rq);
    exp_t e;
    @(negedge clk);
    act = a; stl = s; spn = p; dsp = d; rtr = r; fl = f;
    e.v = ev; e.s = es; e.r = rq;
    q.push_back(e);
  endtask

  // Monitor: compare the settled outputs against the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (vld !== e.v || tid !== e.s) begin
          n_bad++;
          $display("FAIL %s: vld=%0b tid=%0d expected vld=%0b tid=%0d",
                   e.r, vld, tid, e.v, e.s);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    act = '0; stl = '0; spn = '0; fl = '0; dsp = '0; rtr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 R11: nothing active
    step(4'b0000, 0, 0, 0, 0, 0, 1'b0, 2'd0, "R10 no active thread");
    // R1: fresh state, all tied at zero from pointer 0
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd0, "R1 reset state");
    // R4 pointer moved to 1; R2 dispatch 3,2,0,1
    step(4'b1111, 0, 0, pk(3,2,0,1), 0, 0, 1'b1, 2'd1, "R4 rotation after pick");
    // R2 R3: occupancies 3,2,0,1 -> thread 2
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd2, "R3 fewest entries");
    // R6: thread 2 stalled -> thread 3; retire 3 from thread 0
    step(4'b1111, 4'b0100, 0, 0, pk(3,0,0,0), 0, 1'b1, 2'd3, "R6 stalled skipped");
    // R4: occ 0,2,0,1 ptr 0 -> thread 0
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd0, "R4 tie from pointer 0");
    // R4: ptr 1 -> thread 2
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd2, "R4 tie from pointer 1");
    // R5: threads 0,2 spinning -> thread 3 (occ 1) beats thread 1 (occ 2)
    step(4'b1111, 0, 4'b0101, 0, 0, 0, 1'b1, 2'd3, "R5 spinners demoted");
    // R5: all spinning -> pool falls back; ptr 0 -> thread 0
    step(4'b1111, 0, 4'b1111, 0, 0, 0, 1'b1, 2'd0, "R5 all spinning fallback");
    // ptr 1: tie 0s at 2 found first; dispatch 2 to thread 1 -> 4
    step(4'b1111, 0, 0, pk(0,2,0,0), 0, 0, 1'b1, 2'd2, "R2 R4 pick while dispatching");
    // R7: four active, cap 4, thread 1 at 4, others stalled
    step(4'b1111, 4'b1101, 0, 0, 0, 0, 1'b0, 2'd0, "R7 at share cap");
    // R7: two active, cap 8
    step(4'b0011, 4'b0001, 0, 0, 0, 0, 1'b1, 2'd1, "R7 larger share with two");
    // R8: single thread, add 7 -> 11
    step(4'b0010, 0, 0, pk(0,7,0,0), 0, 0, 1'b1, 2'd1, "R8 single thread");
    // R8: occupancy 11 still eligible; add 5 -> 16
    step(4'b0010, 0, 0, pk(0,5,0,0), 0, 0, 1'b1, 2'd1, "R8 above share still fetches");
    // R8: full window
    step(4'b0010, 0, 0, 0, 0, 0, 1'b0, 2'd0, "R8 full window");
    // R7 R9: two active over cap; flush beats dispatch
    step(4'b0011, 4'b0001, 0, pk(0,3,0,0), 0, 4'b0010, 1'b0, 2'd0, "R7 over cap");
    step(4'b0011, 4'b0001, 0, 0, 0, 0, 1'b1, 2'd1, "R9 flush cleared count");
    // R3: occ 0,0,0,1 ptr 2 -> thread 2; retire thread 3
    step(4'b1111, 0, 0, 0, pk(0,0,0,1), 0, 1'b1, 2'd2, "R3 R4 pick with pointer 2");
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd3, "R2 R4 retire evened counts");
    // R6 R10: everything stalled
    step(4'b1111, 4'b1111, 0, 0, 0, 0, 1'b0, 2'd0, "R6 all stalled");
    // R10: pointer held at 0
    step(4'b1111, 0, 0, 0, 0, 0, 1'b1, 2'd0, "R10 pointer held");
    // R5: only a spinning thread is eligible
    step(4'b1111, 4'b1101, 4'b0010, 0, 0, 0, 1'b1, 2'd1, "R5 lone spinner picked");
    step(4'b0000, 0, 0, 0, 0, 0, 1'b0, 2'd0, "R11 inactive ignored");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule